// File: doc/BRIEF.md
# Write-Triggered Accumulator Functional Unit

This block is one functional unit on the move bus of a transport-triggered processor. The processor has no opcodes. Each bus cycle names a source address and a destination address. The unit that matches the source drives the bus, and the unit that matches the destination takes the value. For this accumulator, the operation comes from which subfunction address the operand is written to. A write to one subfunction replaces the accumulator. A write to another adds the operand. A write to a third subtracts it.

The unit compares both bus addresses against a 13-bit unit address supplied on an input port, so identical copies can sit at different places in the address space. The address is split into three fields. Bits [7:0] and bit 12 select the unit, and bits [11:8] carry the subfunction. The unit keeps zero, carry and negative flags that the conditional-move logic can test. Its transfer acknowledge stays high, because every operation finishes in the cycle it is issued. The read data port is a multiplexed-bus output: it carries the accumulator while the unit is the selected source and zero at all other times.

Top module: `acc_fu`

## Requirements
- R1: While rst_n is low and after it is released, the accumulator and the flags flag_zero, flag_carry and flag_neg are all 0 until the first effective write.
- R2: An address selects the unit when its bits [7:0] and bit 12 equal the same bits of unit_addr. Bits [11:8] of unit_addr take no part in the match, and bits [11:8] of the bus address give the subfunction.
- R3: A write to subfunction 0 loads wr_data into the accumulator at the next rising clock edge.
- R4: A write to subfunction 1 adds wr_data to the accumulator, modulo 2^32. flag_carry becomes the carry out of bit 31.
- R5: A write to subfunction 2 subtracts wr_data from the accumulator, modulo 2^32. flag_carry becomes 1 exactly when wr_data is greater than the old accumulator value (borrow), with both treated as unsigned.
- R6: Every write to subfunctions 0 to 2 sets flag_zero to (new value == 0) and flag_neg to bit 31 of the new value. A subfunction 0 load leaves flag_carry unchanged.
- R7: A write to any subfunction from 3 to 15 leaves the accumulator and all three flags unchanged.
- R8: While src_addr selects the unit, rd_data equals the accumulator, whatever the subfunction. Otherwise rd_data is 0. This is combinational, in the same cycle.
- R9: ack is 1 in every cycle, so the unit never stalls the bus.
- R10: A cycle whose dst_addr does not select the unit leaves the accumulator and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_addr | input | 13 | Configured address of this unit |
| src_addr | input | 13 | Source address of the current move |
| dst_addr | input | 13 | Destination address of the current move |
| wr_data | input | 32 | Value moved on the bus this cycle |
| rd_data | output | 32 | Accumulator when selected as source, else 0 |
| ack | output | 1 | Transfer acknowledge, always high |
| flag_zero | output | 1 | Accumulator is zero after the last effective write |
| flag_carry | output | 1 | Carry from the last add, or borrow from the last subtract |
| flag_neg | output | 1 | Bit 31 of the accumulator after the last effective write |

## Verification
The bench drives the arithmetic to its wrap points.
- An add that crosses into the sign bit: a unit that took the flags from the old value would leave flag_neg at 0.
- An add that wraps to zero: a unit that dropped the carry out would miss flag_carry and flag_zero.
- A subtract that borrows: a unit that flagged carry instead of borrow would invert flag_carry.

It also checks the addressing.
- Writes to unused subfunctions, and to addresses that differ only in bit 12 or only in the low byte, must change nothing. A unit that decodes too loosely corrupts the accumulator.
- A unit address whose subfunction field is nonzero must still match. A unit that compares all 13 bits would never respond.
- A load just after a borrow must keep the carry. A unit that cleared carry on every write would lose it.

// File: rtl/acc_fu_pkg.sv
// Shared definitions for the write-triggered accumulator.
// Assumes the bus address layout {select bit, subfunction, unit low byte}.
package acc_fu_pkg;

    // Subfunction codes that cause an effect on write
    localparam logic [3:0] SF_LOAD = 4'd0;
    localparam logic [3:0] SF_ADD  = 4'd1;
    localparam logic [3:0] SF_SUB  = 4'd2;

    // Operation chosen by the destination subfunction
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADD  = 2'd2,
        OP_SUB  = 2'd3
    } acc_op_e;

endpackage

// File: rtl/acc_fu_decode.sv
// Address decoder: matches a bus address against the configured unit
// address on the low field and the top select bit, and extracts the
// subfunction field in between. Assumes ADDR_W > LO_W + 1.
module acc_fu_decode #(
    parameter int ADDR_W = 13,
    parameter int LO_W   = 8
) (
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [ADDR_W-1:0]        cfg_addr,
    output logic                     hit,
    output logic [ADDR_W-LO_W-2:0]   sub
);
    // Compare unit fields, ignore the subfunction field of cfg_addr
    always_comb begin
        hit = (bus_addr[LO_W-1:0] == cfg_addr[LO_W-1:0]) &&
              (bus_addr[ADDR_W-1] == cfg_addr[ADDR_W-1]);
        sub = bus_addr[ADDR_W-2:LO_W];
    end
endmodule

// File: rtl/acc_fu_alu.sv
// Next-state arithmetic: maps the subfunction to an operation and forms
// the new accumulator value and carry/borrow. Purely combinational.
module acc_fu_alu
    import acc_fu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SUB_W  = 4
) (
    input  logic              wr_hit,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output acc_op_e           op,
    output logic [DATA_W-1:0] acc_next,
    output logic              carry_next
);
    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;

    // Select the operation from the destination subfunction
    always_comb begin
        op = OP_NONE;
        if (wr_hit) begin
            case (wr_sub)
                SUB_W'(SF_LOAD): op = OP_LOAD;
                SUB_W'(SF_ADD):  op = OP_ADD;
                SUB_W'(SF_SUB):  op = OP_SUB;
                default:         op = OP_NONE;
            endcase
        end
    end

    // Form sum and difference with one extra bit for carry/borrow
    always_comb begin
        sum_w = {1'b0, acc} + {1'b0, operand};
        dif_w = {1'b0, acc} - {1'b0, operand};
        case (op)
            OP_LOAD: begin acc_next = operand;            carry_next = 1'b0;          end
            OP_ADD:  begin acc_next = sum_w[DATA_W-1:0];  carry_next = sum_w[DATA_W]; end
            OP_SUB:  begin acc_next = dif_w[DATA_W-1:0];  carry_next = dif_w[DATA_W]; end
            default: begin acc_next = acc;                carry_next = 1'b0;          end
        endcase
    end
endmodule

// File: rtl/acc_fu_state.sv
// State holder: accumulator and flags with synchronous active-low reset.
// Assumes op is OP_NONE on cycles that must not change state.
module acc_fu_state
    import acc_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] acc_next,
    input  logic              carry_next,
    output logic [DATA_W-1:0] acc_q,
    output logic              zero_q,
    output logic              carry_q,
    output logic              neg_q
);
    // Update accumulator and zero/negative flags on any effective write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            zero_q <= 1'b0;
            neg_q  <= 1'b0;
        end else if (op != OP_NONE) begin
            acc_q  <= acc_next;
            zero_q <= (acc_next == '0);
            neg_q  <= acc_next[DATA_W-1];
        end
    end

    // Carry only follows arithmetic operations
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (op == OP_ADD || op == OP_SUB)
            carry_q <= carry_next;
    end
endmodule

// File: rtl/acc_fu.sv
// Write-triggered accumulator functional unit for a move-only bus.
// The destination subfunction picks load/add/subtract; the unit drives
// its value on a multiplexed read bus (zero when not the source).
// Assumes one transfer per clock and a unit address stable during use.
module acc_fu
    import acc_fu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 13,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack,
    output logic              flag_zero,
    output logic              flag_carry,
    output logic              flag_neg
);
    localparam int SUB_W = ADDR_W - LO_W - 1;

    logic             src_hit, dst_hit;
    logic [SUB_W-1:0] src_sub, dst_sub;
    acc_op_e          op;
    logic [DATA_W-1:0] acc_next, acc_q;
    logic             carry_next;

    acc_fu_decode #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_src_dec (
        .bus_addr(src_addr), .cfg_addr(unit_addr), .hit(src_hit), .sub(src_sub));

    acc_fu_decode #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_dst_dec (
        .bus_addr(dst_addr), .cfg_addr(unit_addr), .hit(dst_hit), .sub(dst_sub));

    acc_fu_alu #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_alu (
        .wr_hit(dst_hit), .wr_sub(dst_sub), .acc(acc_q), .operand(wr_data),
        .op(op), .acc_next(acc_next), .carry_next(carry_next));

    acc_fu_state #(.DATA_W(DATA_W)) u_state (
        .clk(clk), .rst_n(rst_n), .op(op), .acc_next(acc_next),
        .carry_next(carry_next), .acc_q(acc_q), .zero_q(flag_zero),
        .carry_q(flag_carry), .neg_q(flag_neg));

    // Every read subfunction returns the accumulator; bus is zero otherwise
    always_comb begin
        rd_data = src_hit ? acc_q : '0;
        ack     = 1'b1;
    end

    logic unused_src_sub;
    assign unused_src_sub = ^src_sub;
endmodule

// File: rtl/acc_fu_chk.sv
// Property checker for acc_fu, bound to every instance. Decodes the bus
// addresses from the ports on its own and compares against the state.
module acc_fu_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 13,
    parameter int LO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] unit_addr,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              ack,
    input logic              flag_zero,
    input logic              flag_carry,
    input logic              flag_neg,
    input logic [DATA_W-1:0] acc_q
);
    logic       c_dst, c_src;
    logic [3:0] c_sub;
    // Independent address decode
    always_comb begin
        c_dst = (dst_addr[7:0] == unit_addr[7:0]) && (dst_addr[12] == unit_addr[12]);
        c_src = (src_addr[7:0] == unit_addr[7:0]) && (src_addr[12] == unit_addr[12]);
        c_sub = dst_addr[11:8];
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && !flag_zero && !flag_carry && !flag_neg));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub == 4'd0) |=> (acc_q == $past(wr_data)));

    assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub == 4'd1) |=>
        ({flag_carry, acc_q} == {1'b0, $past(acc_q)} + {1'b0, $past(wr_data)}));

    assert_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub == 4'd2) |=>
        (acc_q == $past(acc_q) - $past(wr_data) && flag_carry == ($past(wr_data) > $past(acc_q))));

    assert_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub <= 4'd2) |=> (flag_zero == (acc_q == '0) && flag_neg == acc_q[DATA_W-1]));

    assert_load_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub == 4'd0) |=> $stable(flag_carry));

    assert_unused_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dst && c_sub > 4'd2) |=>
        ($stable(acc_q) && $stable(flag_zero) && $stable(flag_carry) && $stable(flag_neg)));

    assert_read_mux_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == (c_src ? acc_q : '0));

    assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n) ack);

    assert_foreign_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !c_dst |=> ($stable(acc_q) && $stable(flag_zero) && $stable(flag_carry) && $stable(flag_neg)));
endmodule

bind acc_fu acc_fu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_W(LO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .unit_addr(unit_addr), .src_addr(src_addr),
    .dst_addr(dst_addr), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_neg(flag_neg),
    .acc_q(acc_q));

// File: tb/acc_fu_tb.sv
// Directed bench for acc_fu: one task per scenario, reference model kept
// in the bench and compared through rd_data and the flag ports.
module acc_fu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] unit_addr = 13'h1F42;   // select bit 1, low byte 42, sub field F (ignored)
    logic [12:0] src_addr  = 13'h0000;
    logic [12:0] dst_addr  = 13'h0000;
    logic [31:0] wr_data   = '0;
    logic [31:0] rd_data;
    logic        ack, flag_zero, flag_carry, flag_neg;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_acc;
    logic        m_z, m_c, m_n;

    localparam logic [12:0] IDLE = 13'h0000;

    always #2.5 clk = ~clk;

    acc_fu u_dut (
        .clk(clk), .rst_n(rst_n), .unit_addr(unit_addr), .src_addr(src_addr),
        .dst_addr(dst_addr), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_neg(flag_neg));

    function automatic logic [12:0] me(input logic [3:0] sub);
        return {1'b1, sub, 8'h42};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Compare accumulator (read via subfunction rsub) and flags to the model
    task automatic check_state(input string req, input logic [3:0] rsub);
        @(negedge clk);
        src_addr = me(rsub);
        #1;
        check(req, "acc", rd_data, m_acc);
        check(req, "flags", {29'd0, m_z, m_c, m_n}, {29'd0, flag_zero, flag_carry, flag_neg});
        src_addr = IDLE;
    endtask

    // One move into address a, held for one rising edge
    task automatic move(input logic [12:0] a, input logic [31:0] v);
        @(negedge clk);
        dst_addr = a;
        wr_data  = v;
        @(negedge clk);
        dst_addr = IDLE;
        wr_data  = '0;
    endtask

    task automatic do_load(input logic [31:0] v);
        move(me(4'd0), v);
        m_acc = v; m_z = (v == 0); m_n = v[31];
    endtask

    task automatic do_add(input logic [31:0] v);
        logic [32:0] s;
        move(me(4'd1), v);
        s = {1'b0, m_acc} + {1'b0, v};
        m_acc = s[31:0]; m_c = s[32]; m_z = (m_acc == 0); m_n = m_acc[31];
    endtask

    task automatic do_sub(input logic [31:0] v);
        move(me(4'd2), v);
        m_c = (v > m_acc);
        m_acc = m_acc - v; m_z = (m_acc == 0); m_n = m_acc[31];
    endtask

    task automatic t_reset;
        m_acc = 0; m_z = 0; m_c = 0; m_n = 0;
        repeat (3) @(negedge clk);
        check_state("R1", 4'd0);
        rst_n = 1'b1;
        check_state("R1", 4'd0);
        check("R9", "ack", {31'd0, ack}, 32'd1);
    endtask

    task automatic t_load_add;
        do_load(32'h7FFF_FFFF);
        check_state("R3", 4'd0);
        do_add(32'd1);                       // crosses into sign bit
        check_state("R4", 4'd0);
        check("R6", "neg after add", {31'd0, flag_neg}, 32'd1);
        do_add(32'h8000_0000);               // wraps to zero with carry
        check_state("R4", 4'd0);
        check("R4", "carry", {31'd0, flag_carry}, 32'd1);
    endtask

    task automatic t_sub;
        do_load(32'd5);
        check_state("R6", 4'd0);             // load keeps carry from add
        do_sub(32'd7);                       // borrow
        check_state("R5", 4'd0);
        check("R5", "borrow", {31'd0, flag_carry}, 32'd1);
        do_sub(32'hFFFF_FFFE);               // back to zero, no borrow
        check_state("R5", 4'd0);
        do_load(32'h1234_5678);
        check_state("R6", 4'd0);             // carry stays 0 after load
    endtask

    task automatic t_unused_sub;
        for (int s = 3; s < 16; s++) begin
            move(me(4'(s)), 32'hDEAD_0000 + 32'(s));
            check_state("R7", 4'(s));        // read through the same subfunction (R8)
        end
    endtask

    task automatic t_foreign;
        move(13'h0142, 32'h0);               // select bit differs
        check_state("R10", 4'd0);
        move(13'h1043, 32'h0);               // low byte differs
        check_state("R10", 4'd0);
        do_sub(32'h1);                        // matches though unit sub field is F (R2)
        check_state("R2", 4'd7);
    endtask

    task automatic t_read_mux;
        @(negedge clk);
        src_addr = 13'h1043; #1;
        check("R8", "unselected read", rd_data, 32'd0);
        src_addr = 13'h0142; #1;
        check("R8", "select bit differs", rd_data, 32'd0);
        src_addr = me(4'd2); #1;
        check("R8", "selected read", rd_data, m_acc);
        src_addr = IDLE;
        check("R9", "ack", {31'd0, ack}, 32'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_add();
                t_sub();
                t_unused_sub();
                t_foreign();
                t_read_mux();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule